// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is the serial control port of a clock generator. It is an SMBus target that holds the generator's configuration bytes. It is the only thing that can change them.

A host writes configuration in one indexed block transfer. The host sends the target's address in its write form, a starting index and a byte count. Then it sends that many data bytes, which land at consecutive indices.

A read uses a repeated start. The host writes the address and an index, restarts, and sends the read-form address. The target then returns a count byte first, taken from a writable count register. After the count byte it returns data bytes from the index upward until the host refuses one.

The register contents leave the block as one flat parallel bus. The clock logic around it reads that bus. Read-only fields and reserved bits keep their reset values whatever the host writes.

Top module: `smbus_cfg_regs`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth clock) the address byte 0xD2 (write form) and 0xD3 (read form) for the default 7-bit address 0x69. It does not acknowledge any other address byte, and it leaves SDA released until the next start.
- R2: After 0xD2, the target acknowledges the index byte N and the count byte X. It then acknowledges X data bytes and stores them at indices N, N+1, and so on.
- R3: A data byte that arrives after X bytes have been written is not acknowledged, and it is not stored.
- R4: After a repeated start with 0xD3, the target sends the count register (index 8) first. It then sends the bytes from index N upward, most significant bit first, while the host acknowledges. A host NACK ends the read and SDA is released.
- R5: After reset, indices 1 and 2 read 0xFF, index 8 reads 0x09 and index 3 reads 0x01. Indices 5 and 10 read 0x00, as do all other writable indices.
- R6: Index 6 is read-only at 0x81. Index 7 is read-only at {REV_ID, 4'b0001}. Writes to either index are ignored.
- R7: Some indices accept writes only in selected bits, and every other bit keeps its reset value:
  - index 5: bits 3:2;
  - index 10: bit 7;
  - indices 3 and 4: bits 1:0;
  - indices 14 and 18: bits 6:0;
  - index 20: bits 3:0.
- R8: Writes to indices at or above NUM_REGS are acknowledged and discarded. Reads of those indices return 0x00.
- R9: Index 8 is writable, and the value written becomes the count byte that later reads return.
- R10: Register i appears on regs_o bits [8i+7:8i].
- R11: The target changes SDA only while the synchronised SCL is low. A stop at any point returns the target to idle with SDA released, and the next transfer proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | NUM_REGS*8 | All configuration bytes, index i at bits [8i+7:8i] |

## Verification
The bench builds the block with NUM_REGS at 21 and REV_ID at 3. A nonzero REV_ID makes the read-only vendor byte distinguishable from an all-zero register. Because the index counter is 8 bits wide, a register count of 21 leaves indices such as 30 reachable, and those exercise the unimplemented path. The count register is rewritten mid-run, so the count byte that reads return is seen at two different values.

// File: rtl/smbus_cfg_regs.sv
`timescale 1ns/1ps
module smbus_cfg_regs #(
  parameter logic [6:0] ADDR7    = 7'h69,
  parameter int         NUM_REGS = 21,
  parameter logic [3:0] REV_ID   = 4'h0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int CNT_IDX = 8;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_ADDR = 3'd1, S_IDX = 3'd2, S_CNT = 3'd3,
    S_WR = 3'd4, S_RD = 3'd5, S_DONE = 3'd6
  } st_t;

  function automatic logic [7:0] rst_val(int i);
    case (i)
      1, 2:    return 8'hFF;
      3:       return 8'h01;
      6:       return 8'h81;
      7:       return {REV_ID, 4'b0001};
      8:       return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wr_mask(int i);
    case (i)
      3, 4:    return 8'h03;
      5:       return 8'h0C;
      6, 7:    return 8'h00;
      10:      return 8'h80;
      14, 18:  return 8'h7F;
      20:      return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  logic [2:0] scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire nbit    = sda_q[1];
  wire rise    = scl_q[1] & ~scl_q[2];
  wire fall    = ~scl_q[1] & scl_q[2];
  wire start_c = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  st_t        st;
  logic [3:0] bcnt;
  logic [6:0] sh;
  logic [6:0] tx;
  logic       ackph, ackok, rw, hack;
  logic [7:0] idx, wrem, rd_val;
  logic [7:0] regs [NUM_REGS];

  wire [7:0] nb     = {sh, nbit};
  wire       wr_stb = rise & ~ackph & (st == S_WR) & (bcnt == 4'd7) & (wrem != 8'd0);

  always_comb begin
    rd_val = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == 8'(i)) rd_val = regs[i];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RV = rst_val(g);
    localparam logic [7:0] WM = wr_mask(g);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) regs[g] <= RV;
      else if (wr_stb && idx == 8'(g)) regs[g] <= (regs[g] & ~WM) | (nb & WM);
    assign regs_o[g*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= 4'd0; sh <= 7'd0; tx <= 7'd0;
      ackph <= 1'b0; ackok <= 1'b0; rw <= 1'b0; hack <= 1'b0;
      idx <= 8'd0; wrem <= 8'd0; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; bcnt <= 4'd0; ackph <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; ackph <= 1'b0; sda_oe <= 1'b0;
    end else if (st == S_RD) begin
      if (rise && ackph) hack <= ~nbit;
      if (fall) begin
        if (!ackph) begin
          if (bcnt == 4'd8) begin
            sda_oe <= 1'b0; ackph <= 1'b1;
          end else begin
            tx <= {tx[5:0], 1'b0}; sda_oe <= ~tx[6]; bcnt <= bcnt + 4'd1;
          end
        end else begin
          ackph <= 1'b0;
          if (hack) begin
            tx <= rd_val[6:0]; sda_oe <= ~rd_val[7]; bcnt <= 4'd1; idx <= idx + 8'd1;
          end else begin
            st <= S_DONE; sda_oe <= 1'b0;
          end
        end
      end
    end else if (st inside {S_ADDR, S_IDX, S_CNT, S_WR}) begin
      if (rise && !ackph && bcnt != 4'd8) begin
        sh <= nb[6:0];
        bcnt <= bcnt + 4'd1;
        if (bcnt == 4'd7) begin
          case (st)
            S_ADDR: begin ackok <= (nb[7:1] == ADDR7); rw <= nb[0]; end
            S_IDX:  begin idx <= nb; ackok <= 1'b1; end
            S_CNT:  begin wrem <= nb; ackok <= 1'b1; end
            default: begin
              ackok <= (wrem != 8'd0);
              if (wrem != 8'd0) begin idx <= idx + 8'd1; wrem <= wrem - 8'd1; end
            end
          endcase
        end
      end
      if (fall) begin
        if (!ackph && bcnt == 4'd8) begin
          ackph <= 1'b1; sda_oe <= ackok;
        end else if (ackph) begin
          ackph <= 1'b0; bcnt <= 4'd0; sda_oe <= 1'b0;
          if (!ackok) st <= S_DONE;
          else begin
            case (st)
              S_ADDR:
                if (rw) begin
                  st <= S_RD; tx <= regs[CNT_IDX][6:0];
                  sda_oe <= ~regs[CNT_IDX][7]; bcnt <= 4'd1;
                end else st <= S_IDX;
              S_IDX:   st <= S_CNT;
              S_CNT:   st <= S_WR;
              default: st <= S_WR;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/smbus_cfg_regs_chk.sv
`timescale 1ns/1ps
module smbus_cfg_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic [2:0] st_i,
  input logic [7:0] dev_b,
  input logic [7:0] sel_b
);
  a_r1_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == 3'd6) |-> !sda_oe);

  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i == 3'd0) |-> !sda_oe);

  a_r11_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r6_devid_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    dev_b == 8'h81);

  a_r7_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b & 8'hF3) == 8'h00);
endmodule

bind smbus_cfg_regs smbus_cfg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_q[1]), .sda_oe(sda_oe),
  .st_i(st), .dev_b(regs_o[55:48]), .sel_b(regs_o[47:40])
);

// File: tb/smbus_cfg_regs_tb.sv
`timescale 1ns/1ps
module smbus_cfg_regs_tb;
  localparam int NR = 21;
  logic clk = 1'b0, rst_n = 1'b0, scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  wire sda_line = sda_h & ~sda_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smbus_cfg_regs #(.NUM_REGS(NR), .REV_ID(4'h3)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o));

  string      exp_tag[$];
  logic [7:0] exp_val[$];
  logic [7:0] got_byte;
  event       got_ev;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] rb(int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic push(string tag, logic [7:0] v);
    exp_tag.push_back(tag);
    exp_val.push_back(v);
  endtask

  initial forever begin
    @(got_ev);
    if (exp_val.size() == 0) begin
      checks++; errors++;
      $display("FAIL R4: got %0h expected none", got_byte);
    end else begin
      string t;
      logic [7:0] v;
      t = exp_tag.pop_front();
      v = exp_val.pop_front();
      chk(t, {24'd0, got_byte}, {24'd0, v});
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic bstart();
    if (!scl_h) begin sda_h = 1; tick(4); scl_h = 1; tick(8); end
    else begin sda_h = 1; tick(8); end
    sda_h = 0; tick(8); scl_h = 0;
  endtask

  task automatic bstop();
    sda_h = 0; tick(4); scl_h = 1; tick(8); sda_h = 1; tick(8);
  endtask

  task automatic wbit(bit b);
    tick(2); sda_h = b; tick(6); scl_h = 1; tick(8); scl_h = 0;
  endtask

  task automatic rbit(output bit b);
    sda_h = 1; tick(8); scl_h = 1; tick(4); b = sda_line; tick(4); scl_h = 0;
  endtask

  task automatic wbyte(logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic rbyte(bit nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin bit b; rbit(b); v[i] = b; end
    wbit(nack);
  endtask

  task automatic wr_txn(logic [7:0] n, logic [7:0] x, logic [7:0] d0, logic [7:0] d1,
                        logic [7:0] d2, int nsend, string tag);
    bit a;
    bstart();
    wbyte(8'hD2, a); chk("R1", {31'd0, a}, 1);
    wbyte(n, a);     chk("R2", {31'd0, a}, 1);
    wbyte(x, a);     chk("R2", {31'd0, a}, 1);
    for (int k = 0; k < nsend; k++) begin
      logic [7:0] d;
      d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      wbyte(d, a);
      chk(tag, {31'd0, a}, {31'd0, (k < int'(x))});
    end
    bstop();
  endtask

  task automatic rd_txn(logic [7:0] n, int nbytes);
    bit a;
    bstart();
    wbyte(8'hD2, a); chk("R1", {31'd0, a}, 1);
    wbyte(n, a);     chk("R4", {31'd0, a}, 1);
    bstart();
    wbyte(8'hD3, a); chk("R1", {31'd0, a}, 1);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] v;
      rbyte(k == nbytes - 1, v);
      got_byte = v;
      -> got_ev;
      tick(1);
    end
    bstop();
    tick(4);
  endtask

  initial begin
    bit a;
    tick(5); rst_n = 1; tick(5);
    chk("R5", rb(1), 8'hFF); chk("R5", rb(2), 8'hFF);
    chk("R5", rb(8), 8'h09); chk("R5", rb(3), 8'h01);
    chk("R5", rb(5), 8'h00); chk("R5", rb(10), 8'h00);
    chk("R6", rb(6), 8'h81); chk("R6", rb(7), 8'h31);
    chk("R11", {31'd0, sda_oe}, 0);

    wr_txn(8'd11, 8'd3, 8'hA5, 8'h5A, 8'h3C, 3, "R2");
    chk("R10", regs_o[11*8 +: 24], 24'h3C5AA5);

    wr_txn(8'd5, 8'd3, 8'hFF, 8'h00, 8'h00, 3, "R7");
    chk("R7", rb(5), 8'h0C); chk("R6", rb(6), 8'h81); chk("R6", rb(7), 8'h31);
    wr_txn(8'd10, 8'd1, 8'hFF, 8'h00, 8'h00, 1, "R7");
    chk("R7", rb(10), 8'h80);
    wr_txn(8'd20, 8'd1, 8'hFF, 8'h00, 8'h00, 1, "R7");
    chk("R7", rb(20), 8'h0F);
    wr_txn(8'd14, 8'd1, 8'hFF, 8'h00, 8'h00, 1, "R7");
    chk("R7", rb(14), 8'h7F);

    wr_txn(8'd1, 8'd1, 8'h77, 8'h66, 8'h00, 2, "R3");
    chk("R3", rb(1), 8'h77); chk("R3", rb(2), 8'hFF);

    push("R4", 8'h09); push("R4", 8'hA5); push("R4", 8'h5A); push("R4", 8'h3C);
    rd_txn(8'd11, 4);

    wr_txn(8'd8, 8'd1, 8'h04, 8'h00, 8'h00, 1, "R9");
    chk("R9", rb(8), 8'h04);
    push("R9", 8'h04); push("R7", 8'h0C); push("R6", 8'h81); push("R6", 8'h31);
    rd_txn(8'd5, 4);

    bstart();
    wbyte(8'hA0, a); chk("R1", {31'd0, a}, 0);
    wbyte(8'h00, a); chk("R1", {31'd0, a}, 0);
    bstop();
    chk("R1", rb(1), 8'h77);

    wr_txn(8'd30, 8'd1, 8'h55, 8'h00, 8'h00, 1, "R8");
    push("R8", 8'h04); push("R8", 8'h00);
    rd_txn(8'd30, 2);

    bstart();
    wbyte(8'hD2, a); chk("R11", {31'd0, a}, 1);
    wbyte(8'd12, a); chk("R11", {31'd0, a}, 1);
    bstop();
    chk("R11", {31'd0, sda_line}, 1);
    wr_txn(8'd12, 8'd1, 8'hE7, 8'h00, 8'h00, 1, "R11");
    chk("R11", rb(12), 8'hE7);

    tick(10);
    if (exp_val.size() != 0) begin
      checks++; errors++;
      $display("FAIL R4: got %0d leftover expected 0", exp_val.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule